// File: doc/BRIEF.md
# Timebase Prescaler Divider

The block is a free-running binary prescaler for a small 4-bit microcontroller. A timebase enable from the oscillator section advances a 15-bit count by one on each tick. The count wraps around to zero, and each wrap raises a sticky once-per-second flag. The flag stays up until the core acknowledges it.

The core reaches the divider through instruction strobes that an opcode decoder elsewhere produces:

- A full clear zeroes every stage.
- A partial clear zeroes only the upper stages and keeps the fast low stages.
- A transfer strobe places the four most significant stages on a 4-bit readout for the accumulator path.

The raw count is also exported for other timing logic.

Top module: `tb_divider`

## Requirements
- R1: On a cycle with `tick` high and neither clear strobe high, `count` increments by one. With `tick` low and no clear strobe, `count` holds its value.
- R2: The count wraps from 0x7FFF to 0x0000 on a tick.
- R3: A counting wrap from 0x7FFF to 0 sets `sec_flag` in the same clock edge that zeroes the count.
- R4: `sec_flag` stays set until `sec_ack` is high for a cycle, which clears it. If a wrap and `sec_ack` coincide, the flag ends set.
- R5: `clr_all` forces all 15 count bits to zero. It takes priority over `tick` and over `clr_high`, and it never sets `sec_flag`, even when the count was 0x7FFF.
- R6: `clr_high` without `clr_all` clears count bits 14..7 and keeps bits 6..0 unchanged. It takes priority over `tick`, so the count is not advanced, and it never sets `sec_flag`.
- R7: While `xfer` is high, `rd_data` bit 3 equals count bit 14, bit 2 equals bit 13, bit 1 equals bit 12 and bit 0 equals bit 11. The value comes combinationally from the current count, before that cycle's update. While `xfer` is low, `rd_data` is 0.
- R8: A synchronous active-high `rst` clears `count` and `sec_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one count step per cycle high |
| clr_all | input | 1 | Full divider clear strobe |
| clr_high | input | 1 | Upper-stage clear strobe |
| xfer | input | 1 | Transfer strobe that drives the top stages onto rd_data |
| sec_ack | input | 1 | Acknowledge that clears the one-second flag |
| rd_data | output | 4 | Top four stages of the count, zero when not transferring |
| sec_flag | output | 1 | Sticky one-second flag |
| count | output | 15 | Raw divider count |

## Verification
The bench builds the divider with its default parameters: a 15-bit count, 7 kept low stages and a 4-bit readout. Every wrap therefore costs the real 32768 ticks, and the bench spends two full periods on them. The first period also walks the readout through every value of the top four stages. The second lines up an acknowledge with the exact wrap edge. The full width lets a partial clear from a count with high bits set show that the low seven bits survive. It also lets a clear at 0x7FFF show that no flag comes from clearing.

// File: rtl/tb_divider.sv
module tb_divider #(
  parameter int CNT_W  = 15,
  parameter int KEEP_W = 7,
  parameter int RD_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr_all,
  input  logic             clr_high,
  input  logic             xfer,
  input  logic             sec_ack,
  output logic [RD_W-1:0]  rd_data,
  output logic             sec_flag,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] KEEP_MASK = CNT_W'((1 << KEEP_W) - 1);
  localparam logic [CNT_W-1:0] TOP       = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             advance;
  logic             wrap;

  assign advance = tick & ~clr_all & ~clr_high;
  assign wrap    = advance & (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (clr_all)  cnt_q <= '0;
    else if (clr_high) cnt_q <= cnt_q & KEEP_MASK;
    else if (advance)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (wrap)    flag_q <= 1'b1;
    else if (sec_ack) flag_q <= 1'b0;
  end

  for (genvar i = 0; i < RD_W; i++) begin : g_rd
    assign rd_data[i] = xfer & cnt_q[CNT_W-RD_W+i];
  end

  assign count    = cnt_q;
  assign sec_flag = flag_q;
endmodule

module tb_divider_chk #(
  parameter int CNT_W  = 15,
  parameter int KEEP_W = 7,
  parameter int RD_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             clr_all,
  input logic             clr_high,
  input logic             xfer,
  input logic             sec_ack,
  input logic [RD_W-1:0]  rd_data,
  input logic             sec_flag,
  input logic [CNT_W-1:0] count
);
  // R1
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_all && !clr_high) |=> count == CNT_W'($past(count) + 1'b1));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr_all && !clr_high) |=> $stable(count));
  // R5
  full_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> count == '0);
  // R6
  part_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_high && !clr_all) |=> (count[CNT_W-1:KEEP_W] == '0) &&
                               (count[KEEP_W-1:0] == $past(count[KEEP_W-1:0])));
  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_all && !clr_high && count == '1) |=> sec_flag);
  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_flag && !sec_ack) |=> sec_flag);
  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_flag) |-> $past(count) == '1 && $past(tick) && !$past(clr_all) && !$past(clr_high));
  // R7
  idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |-> rd_data == '0);
endmodule

bind tb_divider tb_divider_chk #(.CNT_W(CNT_W), .KEEP_W(KEEP_W), .RD_W(RD_W)) u_chk (.*);

// File: tb/tb_divider_test.sv
module tb_divider_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, clr_all = 1'b0, clr_high = 1'b0, xfer = 1'b0, sec_ack = 1'b0;
  logic [3:0]  rd_data;
  logic        sec_flag;
  logic [14:0] count;

  int tests = 0, fails = 0;
  logic [14:0] m_cnt = '0;
  logic        m_flag = 1'b0;
  logic [15:0] expq[$];
  string       tagq[$];

  tb_divider uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic t, logic ca, logic ch, logic xf, logic ak);
    logic [3:0] exp_rd;
    logic       w;
    @(negedge clk);
    tick = t; clr_all = ca; clr_high = ch; xfer = xf; sec_ack = ak;
    #1;
    exp_rd = xf ? {m_cnt[14], m_cnt[13], m_cnt[12], m_cnt[11]} : 4'h0;
    check({tag, " R7 readout"}, 32'(rd_data), 32'(exp_rd));
    w = 1'b0;
    if (ca)      m_cnt = '0;
    else if (ch) m_cnt = m_cnt & 15'h007F;
    else if (t) begin
      w = (m_cnt == 15'h7FFF);
      m_cnt = m_cnt + 15'd1;
    end
    if (w)       m_flag = 1'b1;
    else if (ak) m_flag = 1'b0;
    expq.push_back({m_flag, m_cnt});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [15:0] e;
      string       tg;
      e  = expq.pop_front();
      tg = tagq.pop_front();
      check({tg, " count"}, 32'(count), 32'(e[14:0]));
      check({tg, " flag"}, 32'(sec_flag), 32'(e[15]));
    end
  end

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 reset count", 32'(count), 0);
    check("R8 reset flag", 32'(sec_flag), 0);
    for (int i = 0; i < 5; i++) step("R1 tick", 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R1 idle", 0, 0, 0, 1, 0);
    step("R5 clr beats tick", 1, 1, 0, 0, 0);
    for (int i = 0; i < 23100; i++) step("R7 walk", 1, 0, 0, 1, 0);
    step("R6 partial clr beats tick", 1, 0, 1, 1, 0);
    for (int i = 0; i < 9000; i++) step("R1 run", 1, 0, 0, 1, 0);
    step("R5 both clears", 1, 1, 1, 0, 0);
    for (int i = 0; i < 32767; i++) step("R7 walk2", 1, 0, 0, 1, 0);
    step("R2 wrap", 1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) step("R4 flag holds", 1, 0, 0, 0, 0);
    step("R4 ack clears", 0, 0, 0, 0, 1);
    for (int i = 0; i < 32763; i++) step("R1 run2", 1, 0, 0, 0, 0);
    step("R3 R4 wrap with ack", 1, 0, 0, 0, 1);
    step("R4 ack", 0, 0, 0, 0, 1);
    for (int i = 0; i < 32767; i++) step("R1 run3", 1, 0, 0, 0, 0);
    step("R5 clr at top no flag", 1, 1, 0, 1, 0);
    step("R1 after clr", 1, 0, 0, 0, 0);
    @(negedge clk);
    tick = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = '0; m_flag = 1'b0;
    expq.delete(); tagq.delete();
    check("R8 mid reset count", 32'(count), 0);
    check("R8 mid reset flag", 32'(sec_flag), 0);
    step("R7 idle readout", 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule